// File: doc/BRIEF.md
# Clock Generator Configuration Slave (Two-Wire Block-Write)

This block is the serial configuration front end of a multi-output clock generator. It listens on a two-wire serial bus (clock and open-drain data). It holds the registers that enable each clock output, force all outputs into tristate, set up spread-spectrum modulation, pick the frequency-table index and set two output skew codes. A host writes the registers with a block transfer. After the address byte, the host sends two bytes, a command byte and a byte count. The slave acknowledges both and discards them. Every data byte after them goes to the next register, starting at register 0. A read transfer returns two placeholder bytes and then the registers in order.

Both bus lines are synchronized into the system clock. START and STOP are taken from data edges while the bus clock is high. A five-state machine runs each transfer:
- `ST_IDLE` moves to `ST_RECV` on a START.
- `ST_RECV` shifts in eight bits. It then goes to `ST_ACK`, or back to `ST_IDLE` when the address does not match.
- `ST_ACK` holds data low for one bus-clock period. It then goes to `ST_SEND` for a read, or to `ST_RECV` for a write.
- `ST_SEND` shifts out eight bits and goes to `ST_MACK`.
- `ST_MACK` samples the host's acknowledge. A NACK leads to `ST_IDLE`; an ACK leads back to `ST_SEND` with the next byte loaded.
- From any state, a STOP forces `ST_IDLE` and a START forces `ST_RECV`.

The five frequency strap pins are latched once, when reset is released. The latched value drives the frequency index in hardware mode and reads back in register 0.

Top module: `clkcfg_smbus_slave`

## Requirements
- R1: The slave acknowledges only the address byte whose upper seven bits equal DEV_ADDR (default 7'h69). Any other address gets no acknowledge, and the rest of that transfer is ignored until the next START.
- R2: After a matching write address, the command byte and the count byte are both acknowledged, and their values have no effect. The first data byte always lands in register 0.
- R3: Each later data byte goes to the next register and is acknowledged. Bytes beyond register 12 are acknowledged and discarded. Registers change only when a data byte is written.
- R4: Reset loads these defaults: registers 1, 2 and 3 are 8'hFF, register 0 bits 2..0 are 3'b101, register 4 is 8'h00, register 5 is 8'h93, and registers 6..10 are 8'h00. No other event restores the defaults.
- R5: sdram_en[7:0] equals register 1 and sdram_en[12:8] equals register 3 bits 4..0. pci_en equals register 2. m66_en equals register 3 bits 7..5. cpu_en equals register 5 bits 1..0.
- R6: tristate_all equals register 4 bit 0.
- R7: Register 0 sets the spread-spectrum outputs: ss_enable = bit 1, ss_center = bit 0, ss_narrow = bit 2.
- R8: When register 4 bit 3 is 0, freq_index = {1'b0, latched straps}. When it is 1, freq_index = {bit1, bit2, bits7..4} of register 4.
- R9: skew_cpu_sdram equals register 5 bits 7..5 and skew_cpu_m66 equals register 5 bits 4..2.
- R10: strap_fs is sampled once, in the first clock after reset is released. Register 0 bits 7..3 read back straps 0,1,2,3,4 (bit 7 = strap 0). Writes to those bits are ignored.
- R11: Registers 11 and 12 always read 8'h50 and 8'h22, and writes to them are ignored.
- R12: A read returns 8'h00, then 8'd13, then registers 0..12, each MSB first. It returns 8'hFF past register 12. A host NACK ends the transfer.
- R13: The slave only ever pulls data low. A STOP at any point returns it to idle and releases the data line. A repeated START begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-up reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls the data line low |
| strap_fs | input | 5 | Frequency strap pins, strap 0 in bit 0 |
| sdram_en | output | 13 | Memory clock enables |
| pci_en | output | 8 | Peripheral clock enables |
| m66_en | output | 3 | 66 MHz output enables |
| cpu_en | output | 2 | Processor clock enables |
| tristate_all | output | 1 | Force every clock output to tristate |
| ss_enable | output | 1 | Spread spectrum on |
| ss_center | output | 1 | 1 = center spread, 0 = down spread |
| ss_narrow | output | 1 | 1 = reduced spread amplitude |
| freq_index | output | 6 | Frequency table index |
| skew_cpu_sdram | output | 3 | Processor-to-memory skew code |
| skew_cpu_m66 | output | 3 | Processor-to-66 MHz skew code |

## Verification
The bench checks four failure modes.
- The discarded command and count bytes carry non-zero, distinctive values. A slave that stored either one would shift every register down, and the enable patterns would come out misplaced.
- A burst of fifteen data bytes runs past the last register. An index that wrapped would overwrite register 0 or the identification bytes.
- The straps change after reset. A design that sampled them continuously would change both freq_index and the register 0 readback.
- A STOP arrives mid-byte, and a repeated START follows a command byte. A slave that lost track of the byte phase would misalign the next write or return the wrong placeholder on read.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

    localparam int REG_COUNT = 13;
    localparam int IDX_W     = $clog2(REG_COUNT + 3);
    localparam int BYTE_W    = IDX_W;

    localparam int REG_SS    = 0;
    localparam int REG_SDLO  = 1;
    localparam int REG_PCI   = 2;
    localparam int REG_MIX   = 3;
    localparam int REG_MODE  = 4;
    localparam int REG_SKEW  = 5;
    localparam int REG_ID_A  = 11;
    localparam int REG_ID_B  = 12;

    localparam logic [7:0] ID_A_VAL = 8'h50;
    localparam logic [7:0] ID_B_VAL = 8'h22;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECV,
        ST_ACK,
        ST_SEND,
        ST_MACK
    } bus_state_e;

    function automatic logic [7:0] reg_default(input int idx);
        case (idx)
            REG_SS:                     return 8'h05;
            REG_SDLO, REG_PCI, REG_MIX: return 8'hFF;
            REG_SKEW:                   return 8'h93;
            REG_ID_A:                   return ID_A_VAL;
            REG_ID_B:                   return ID_B_VAL;
            default:                    return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/clkcfg_bus_sense.sv
module clkcfg_bus_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_lvl,
    output logic start_det,
    output logic stop_det
);
    logic [2:0] scl_pipe;
    logic [2:0] sda_pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[1:0], scl_i};
            sda_pipe <= {sda_pipe[1:0], sda_i};
        end
    end

    assign scl_rise  = scl_pipe[1] & ~scl_pipe[2];
    assign scl_fall  = ~scl_pipe[1] & scl_pipe[2];
    assign sda_lvl   = sda_pipe[1];
    assign start_det = scl_pipe[1] & scl_pipe[2] & sda_pipe[2] & ~sda_pipe[1];
    assign stop_det  = scl_pipe[1] & scl_pipe[2] & ~sda_pipe[2] & sda_pipe[1];

endmodule

// File: rtl/clkcfg_regs.sv
module clkcfg_regs
    import clkcfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [4:0]       strap_fs,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    output logic [12:0]      sdram_en,
    output logic [7:0]       pci_en,
    output logic [2:0]       m66_en,
    output logic [1:0]       cpu_en,
    output logic             tristate_all,
    output logic             ss_enable,
    output logic             ss_center,
    output logic             ss_narrow,
    output logic [5:0]       freq_index,
    output logic [2:0]       skew_cpu_sdram,
    output logic [2:0]       skew_cpu_m66
);
    localparam int FLAT_W = REG_COUNT * 8;

    logic [FLAT_W-1:0] flat;
    logic [4:0]        strap_q;
    logic              strap_taken;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strap_q     <= '0;
            strap_taken <= 1'b0;
        end else if (!strap_taken) begin
            strap_q     <= strap_fs;
            strap_taken <= 1'b1;
        end
    end

    for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
        if (g == REG_ID_A || g == REG_ID_B) begin : g_ro
            assign flat[g*8 +: 8] = reg_default(g);
        end else if (g == REG_SS) begin : g_ss
            logic [2:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q <= reg_default(g) >> 0;
                else if (wr_en && wr_idx == IDX_W'(g))
                    q <= wr_data[2:0];
            end
            assign flat[g*8 +: 8] = {strap_q[0], strap_q[1], strap_q[2],
                                     strap_q[3], strap_q[4], q};
        end else begin : g_rw
            logic [7:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q <= reg_default(g);
                else if (wr_en && wr_idx == IDX_W'(g))
                    q <= wr_data;
            end
            assign flat[g*8 +: 8] = q;
        end
    end

    always_comb begin
        rd_data = 8'hFF;
        for (int k = 0; k < REG_COUNT; k++) begin
            if (rd_idx == IDX_W'(k))
                rd_data = flat[k*8 +: 8];
        end
    end

    logic [7:0] r0, r1, r2, r3, r4, r5;
    assign r0 = flat[REG_SS*8   +: 8];
    assign r1 = flat[REG_SDLO*8 +: 8];
    assign r2 = flat[REG_PCI*8  +: 8];
    assign r3 = flat[REG_MIX*8  +: 8];
    assign r4 = flat[REG_MODE*8 +: 8];
    assign r5 = flat[REG_SKEW*8 +: 8];

    assign sdram_en       = {r3[4:0], r1};
    assign pci_en         = r2;
    assign m66_en         = r3[7:5];
    assign cpu_en         = r5[1:0];
    assign tristate_all   = r4[0];
    assign ss_enable      = r0[1];
    assign ss_center      = r0[0];
    assign ss_narrow      = r0[2];
    assign skew_cpu_sdram = r5[7:5];
    assign skew_cpu_m66   = r5[4:2];
    assign freq_index     = r4[3] ? {r4[1], r4[2], r4[7:4]} : {1'b0, strap_q};

    // R6: a write to the mode register shows on tristate_all one cycle later
    p_tristate_follows_write_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_W'(REG_MODE)) |=> (tristate_all == $past(wr_data[0])));

    // R3: without a write strobe no enable or skew output moves
    p_hold_without_write_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(sdram_en) && $stable(pci_en) && $stable(m66_en)
                    && $stable(cpu_en) && $stable(skew_cpu_sdram) && $stable(skew_cpu_m66)));

    // R10: once taken, the latched straps never change
    p_strap_frozen_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        strap_taken |=> $stable(strap_q));

endmodule

// File: rtl/clkcfg_smbus_slave.sv
module clkcfg_smbus_slave
    import clkcfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe,
    input  logic [4:0]  strap_fs,
    output logic [12:0] sdram_en,
    output logic [7:0]  pci_en,
    output logic [2:0]  m66_en,
    output logic [1:0]  cpu_en,
    output logic        tristate_all,
    output logic        ss_enable,
    output logic        ss_center,
    output logic        ss_narrow,
    output logic [5:0]  freq_index,
    output logic [2:0]  skew_cpu_sdram,
    output logic [2:0]  skew_cpu_m66
);
    localparam logic [BYTE_W-1:0] BYTE_LAST = BYTE_W'(REG_COUNT + 2);

    logic scl_rise, scl_fall, sda_lvl, start_det, stop_det;

    clkcfg_bus_sense i_sense (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_lvl   (sda_lvl),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    bus_state_e        state, state_d;
    logic [3:0]        bit_cnt;
    logic [7:0]        shreg;
    logic              addr_phase;
    logic              rw;
    logic [BYTE_W-1:0] byte_no;
    logic [BYTE_W-1:0] byte_next;
    logic [BYTE_W-1:0] reg_pos;
    logic              addr_hit, byte_done, in_range, wr_en;
    logic [7:0]        rd_data, rd_byte;

    assign addr_hit  = (shreg[7:1] == DEV_ADDR);
    assign byte_done = (state == ST_RECV) && scl_fall && (bit_cnt == 4'd8);
    assign byte_next = (byte_no == BYTE_LAST) ? byte_no : byte_no + 1'b1;
    assign reg_pos   = byte_no - BYTE_W'(2);
    assign in_range  = (byte_no >= BYTE_W'(2)) && (byte_no < BYTE_LAST);
    assign wr_en     = byte_done && !addr_phase && !rw && in_range;
    assign rd_byte   = (byte_no == '0)          ? 8'h00 :
                       (byte_no == BYTE_W'(1))  ? 8'(REG_COUNT) : rd_data;

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: ;
            ST_RECV: if (byte_done)
                         state_d = (addr_phase && !addr_hit) ? ST_IDLE : ST_ACK;
            ST_ACK:  if (scl_fall) state_d = rw ? ST_SEND : ST_RECV;
            ST_SEND: if (scl_fall && bit_cnt == 4'd7) state_d = ST_MACK;
            ST_MACK: if (scl_rise && sda_lvl) state_d = ST_IDLE;
                     else if (scl_fall)       state_d = ST_SEND;
        endcase
        if (stop_det)  state_d = ST_IDLE;
        if (start_det) state_d = ST_RECV;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            shreg      <= '0;
            addr_phase <= 1'b1;
            rw         <= 1'b0;
            byte_no    <= '0;
        end else if (start_det) begin
            bit_cnt    <= '0;
            addr_phase <= 1'b1;
        end else begin
            unique case (state)
                ST_RECV: begin
                    if (scl_rise && bit_cnt != 4'd8) begin
                        shreg   <= {shreg[6:0], sda_lvl};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                    if (byte_done) begin
                        bit_cnt <= '0;
                        if (addr_phase) begin
                            if (addr_hit) begin
                                rw         <= shreg[0];
                                byte_no    <= '0;
                                addr_phase <= 1'b0;
                            end
                        end else begin
                            byte_no <= byte_next;
                        end
                    end
                end
                ST_ACK, ST_MACK: begin
                    if (scl_fall && rw) begin
                        shreg   <= rd_byte;
                        byte_no <= byte_next;
                        bit_cnt <= '0;
                    end
                end
                ST_SEND: begin
                    if (scl_fall) begin
                        shreg   <= {shreg[6:0], 1'b1};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_IDLE: ;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            ST_ACK:  sda_oe = 1'b1;
            ST_SEND: sda_oe = ~shreg[7];
            default: sda_oe = 1'b0;
        endcase
    end

    clkcfg_regs i_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .strap_fs       (strap_fs),
        .wr_en          (wr_en),
        .wr_idx         (reg_pos),
        .wr_data        (shreg),
        .rd_idx         (reg_pos),
        .rd_data        (rd_data),
        .sdram_en       (sdram_en),
        .pci_en         (pci_en),
        .m66_en         (m66_en),
        .cpu_en         (cpu_en),
        .tristate_all   (tristate_all),
        .ss_enable      (ss_enable),
        .ss_center      (ss_center),
        .ss_narrow      (ss_narrow),
        .freq_index     (freq_index),
        .skew_cpu_sdram (skew_cpu_sdram),
        .skew_cpu_m66   (skew_cpu_m66)
    );

    // R13: a STOP always leaves the data line released
    p_release_after_stop_r13 : assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R1: a foreign address is never acknowledged
    p_addr_miss_no_ack_r1 : assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && addr_phase && !addr_hit && !start_det && !stop_det) |=> !sda_oe);

    // R12: a host NACK ends the read
    p_nack_ends_read_r12 : assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MACK && scl_rise && sda_lvl && !start_det) |=> (state == ST_IDLE));

    // R3: after a register write the byte position has moved on
    p_pos_advances_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !start_det) |=> (byte_no == $past(byte_no) + 1'b1));

endmodule

// File: tb/test_clkcfg_smbus_slave.sv
module test_clkcfg_smbus_slave;

    localparam int Q = 20;
    localparam logic [7:0] ADDR_W = 8'hD2;
    localparam logic [7:0] ADDR_R = 8'hD3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [4:0]  strap_fs = 5'b10110;
    logic        sda_oe;
    logic [12:0] sdram_en;
    logic [7:0]  pci_en;
    logic [2:0]  m66_en;
    logic [1:0]  cpu_en;
    logic        tristate_all, ss_enable, ss_center, ss_narrow;
    logic [5:0]  freq_index;
    logic [2:0]  skew_cpu_sdram, skew_cpu_m66;
    wire         sda_line;

    assign sda_line = sda_m & ~sda_oe;

    always #2 clk = ~clk;

    clkcfg_smbus_slave i_clkcfg_smbus_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .strap_fs(strap_fs), .sdram_en(sdram_en), .pci_en(pci_en), .m66_en(m66_en),
        .cpu_en(cpu_en), .tristate_all(tristate_all), .ss_enable(ss_enable),
        .ss_center(ss_center), .ss_narrow(ss_narrow), .freq_index(freq_index),
        .skew_cpu_sdram(skew_cpu_sdram), .skew_cpu_m66(skew_cpu_m66)
    );

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    logic [4:0] boot_strap = 5'b10110;
    logic [7:0] model [0:12];
    logic [7:0] wbuf [0:15];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(); scl_m = 1'b1; wq(); scl_m = 1'b0;
        end
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
        acked = ~sda_line;
        scl_m = 1'b0; wq();
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(); scl_m = 1'b1; wq(); b[i] = sda_line; scl_m = 1'b0;
        end
        sda_m = nack; wq(); scl_m = 1'b1; wq(); scl_m = 1'b0; wq();
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] exp_reg(input int k);
        if (k == 0)  return {boot_strap[0], boot_strap[1], boot_strap[2],
                             boot_strap[3], boot_strap[4], model[0][2:0]};
        if (k == 11) return 8'h50;
        if (k == 12) return 8'h22;
        if (k > 12)  return 8'hFF;
        return model[k];
    endfunction

    task automatic wr_burst(input int n, input string tag);
        logic a;
        int nacks = 0;
        bus_start();
        send_byte(ADDR_W, a); if (!a) nacks++;
        send_byte(8'hA5, a);  if (!a) nacks++;
        send_byte(8'h3C, a);  if (!a) nacks++;
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], a);
            if (!a) nacks++;
            if (i < 11) model[i] = wbuf[i];
        end
        bus_stop();
        chk({tag, " all bytes acknowledged"}, nacks, 0);
    endtask

    task automatic rd_burst(input int n, input string tag);
        logic a;
        logic [7:0] b;
        logic [7:0] e;
        bus_start();
        send_byte(ADDR_R, a);
        chk({tag, " read address ack"}, a, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i == n - 1, b);
            e = (i == 0) ? 8'h00 : (i == 1) ? 8'd13 : exp_reg(i - 2);
            chk($sformatf("%s read byte %0d", tag, i), b, e);
        end
        bus_stop();
        chk({tag, " line released after NACK"}, sda_oe, 0);
    endtask

    task automatic t_reset();
        chk("R4 sdram_en default", sdram_en, 13'h1FFF);
        chk("R4 pci_en default", pci_en, 8'hFF);
        chk("R4 m66/cpu default", {m66_en, cpu_en}, 5'b11111);
        chk("R4 R7 spread default", {ss_narrow, ss_enable, ss_center}, 3'b101);
        chk("R4 R6 tristate default", tristate_all, 0);
        chk("R4 R9 skew default", {skew_cpu_sdram, skew_cpu_m66}, 6'b100100);
        chk("R4 R8 hw index default", freq_index, {1'b0, boot_strap});
        chk("R13 idle release", sda_oe, 0);
    endtask

    task automatic t_addr_miss();
        logic a;
        bus_start();
        send_byte(8'hA0, a);
        chk("R1 foreign address not acked", a, 0);
        send_byte(8'h00, a);
        chk("R1 following byte not acked", a, 0);
        bus_stop();
        chk("R1 outputs untouched", {sdram_en, pci_en}, {13'h1FFF, 8'hFF});
    endtask

    task automatic t_write_seq();
        wbuf[0] = 8'hFA; wbuf[1] = 8'h3C; wbuf[2] = 8'h81;
        wbuf[3] = 8'h55; wbuf[4] = 8'hDA; wbuf[5] = 8'h7A;
        wr_burst(6, "R2 R3");
        chk("R2 R7 spread from reg0", {ss_narrow, ss_enable, ss_center}, 3'b010);
        chk("R5 sdram_en", sdram_en, 13'h153C);
        chk("R5 pci_en", pci_en, 8'h81);
        chk("R5 m66_en", m66_en, 3'b010);
        chk("R5 cpu_en", cpu_en, 2'b10);
        chk("R8 software index", freq_index, 6'd45);
        chk("R6 tristate off", tristate_all, 0);
        chk("R9 skews", {skew_cpu_sdram, skew_cpu_m66}, {3'd3, 3'd6});
        rd_burst(16, "R12 R10");
    endtask

    task automatic t_tristate_hw();
        wbuf[0] = 8'h05; wbuf[1] = 8'hFF; wbuf[2] = 8'hFF;
        wbuf[3] = 8'hFF; wbuf[4] = 8'h01;
        wr_burst(5, "R6");
        chk("R6 tristate on", tristate_all, 1);
        chk("R8 hardware index", freq_index, {1'b0, boot_strap});
    endtask

    task automatic t_strap_hold();
        strap_fs = 5'b01001;
        wq();
        chk("R10 index ignores late straps", freq_index, {1'b0, boot_strap});
        rd_burst(3, "R10");
    endtask

    task automatic t_overrun();
        for (int i = 0; i < 15; i++) wbuf[i] = 8'h00;
        wr_burst(15, "R3 R11 overrun");
        chk("R3 enables cleared", {sdram_en, pci_en, m66_en, cpu_en}, 26'h0);
        chk("R3 R9 skews cleared", {skew_cpu_sdram, skew_cpu_m66}, 6'h0);
        rd_burst(16, "R11 R12");
    endtask

    task automatic t_restart();
        logic a;
        logic [7:0] b;
        bus_start();
        send_byte(ADDR_W, a);
        send_byte(8'h07, a);
        bus_start();
        send_byte(ADDR_R, a);
        chk("R13 repeated start address ack", a, 1);
        recv_byte(1'b0, b);
        chk("R13 R12 placeholder after restart", b, 8'h00);
        recv_byte(1'b1, b);
        chk("R12 count placeholder", b, 8'd13);
        bus_stop();
        bus_start();
        send_byte(ADDR_W, a);
        for (int i = 0; i < 3; i++) begin
            sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); scl_m = 1'b0;
        end
        wq();
        bus_stop();
        chk("R13 released after mid-byte stop", sda_oe, 0);
        wbuf[0] = 8'h03;
        wr_burst(1, "R13 R2");
        chk("R13 R2 clean write after abort", {ss_narrow, ss_enable, ss_center}, 3'b011);
    endtask

    initial begin
        for (int k = 0; k < 13; k++) model[k] = 8'h00;
        model[0] = 8'h05; model[1] = 8'hFF; model[2] = 8'hFF;
        model[3] = 8'hFF; model[5] = 8'h93;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (5) @(posedge clk);
        #1;
        t_reset();
        t_addr_miss();
        t_write_seq();
        t_tristate_hw();
        t_strap_hold();
        t_overrun();
        t_restart();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL R13 watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule